// File: doc/BRIEF.md
# Configurable Bidirectional I/O Cell

This block is one I/O cell placed in a boundary tile of a programmable fabric. It connects a fabric-side data pair, one signal going toward the pad and one coming back from it, to the pad-side signals of the surrounding SoC. The direction is held in a single configuration flip-flop inside the cell. When that bit is 1 the cell receives from the pad, and when it is 0 the cell drives the pad. The bit is written through a serial port with a clock, an enable, a data input and a data output, so the cells of a boundary ring can be chained into one shift register.

An active-low isolation input overrides the stored bit and forces receive mode. This keeps the cell from driving the pad while configuration is not yet valid. Whichever data path is inactive is gated to logic 0, so neither side sees a stray value. All `DATA_W` lanes share the one direction bit.

Top module: `fabric_io_cell`

## Requirements
- R1: While `rst_ni` is low and after it is released, the direction bit is 1. The cell is in receive mode with `pad_oe_o`=0 and `cfg_sdo_o`=1.
- R2: On a rising `cfg_clk_i` with `cfg_en_i`=1, the direction bit takes `cfg_sdi_i`. `cfg_sdo_o` always shows the stored bit, so the value shifted in appears at `cfg_sdo_o` after that edge.
- R3: On a rising `cfg_clk_i` with `cfg_en_i`=0, the direction bit keeps its value whatever `cfg_sdi_i` is.
- R4: With the bit at 1 and `iso_ni`=1 (receive mode), `fab_in_o` equals `pad_in_i`, `pad_out_o` is all zeros and `pad_oe_o`=0.
- R5: With the bit at 0 and `iso_ni`=1 (drive mode), `pad_out_o` equals `fab_out_i`, `pad_oe_o`=1 and `fab_in_o` is all zeros.
- R6: With `iso_ni`=0, the cell behaves as in R4 whatever the stored bit holds.
- R7: Asserting `iso_ni` does not change the stored bit. Once `iso_ni` returns to 1, the mode given by the bit returns and `cfg_sdo_o` is unchanged.
- R8: Every lane of the data buses is passed or gated independently of its neighbours, and all lanes follow the one direction bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk_i | input | 1 | Configuration clock |
| rst_ni | input | 1 | Asynchronous reset, active low; sets the direction bit to 1 |
| cfg_en_i | input | 1 | Shift enable for the direction bit |
| cfg_sdi_i | input | 1 | Serial configuration data in |
| cfg_sdo_o | output | 1 | Serial configuration data out (stored bit) |
| iso_ni | input | 1 | Isolation, active low; forces receive mode |
| fab_out_i | input | DATA_W | Fabric data toward the pad |
| fab_in_o | output | DATA_W | Pad data toward the fabric, gated |
| pad_out_o | output | DATA_W | Data driven to the pad, gated |
| pad_oe_o | output | 1 | Pad output enable, active high |
| pad_in_i | input | DATA_W | Data received from the pad |

## Verification
The bench tries all four combinations of stored bit and isolation level. It uses complementary lane patterns (0xA5 and 0x5A), which separate a lane-swap or a stuck-gate fault from correct gating, and all-ones on both buses, which shows whether the inactive side leaks. Toggling `cfg_sdi_i` while `cfg_en_i` is low separates a held bit from a free-running shift. Pulsing isolation while in drive mode shows whether the override only masks the mode or corrupts the stored bit.

// File: rtl/io_cell_pkg.sv
package io_cell_pkg;
  typedef enum logic {
    DIR_DRIVE   = 1'b0,
    DIR_RECEIVE = 1'b1
  } dir_e;

  localparam dir_e DIR_RESET = DIR_RECEIVE;
endpackage

// File: rtl/io_cfg_bit.sv
module io_cfg_bit
  import io_cell_pkg::*;
(
  input  logic cfg_clk_i,
  input  logic rst_ni,
  input  logic cfg_en_i,
  input  logic cfg_sdi_i,
  output dir_e dir_o,
  output logic cfg_sdo_o
);
  dir_e dir_q;

  always_ff @(posedge cfg_clk_i or negedge rst_ni) begin
    if (!rst_ni)       dir_q <= DIR_RESET;
    else if (cfg_en_i) dir_q <= dir_e'(cfg_sdi_i);
  end

  assign dir_o     = dir_q;
  assign cfg_sdo_o = dir_q;

  assert_shift_R2: assert property (@(posedge cfg_clk_i) disable iff (!rst_ni)
    cfg_en_i |=> cfg_sdo_o == $past(cfg_sdi_i));
  assert_hold_R3: assert property (@(posedge cfg_clk_i) disable iff (!rst_ni)
    !cfg_en_i |=> $stable(cfg_sdo_o));
endmodule

// File: rtl/io_dir_ctrl.sv
module io_dir_ctrl
  import io_cell_pkg::*;
(
  input  dir_e dir_i,
  input  logic iso_ni,
  output logic drive_o
);
  // isolation wins over the stored direction
  always_comb begin
    drive_o = 1'b0;
    if (iso_ni && dir_i == DIR_DRIVE) drive_o = 1'b1;
  end
endmodule

// File: rtl/io_path_gate.sv
module io_path_gate #(
  parameter int DATA_W = 8
) (
  input  logic              drive_i,
  input  logic [DATA_W-1:0] fab_out_i,
  input  logic [DATA_W-1:0] pad_in_i,
  output logic [DATA_W-1:0] pad_out_o,
  output logic [DATA_W-1:0] fab_in_o
);
  for (genvar g = 0; g < DATA_W; g++) begin : g_lane
    assign pad_out_o[g] = fab_out_i[g] & drive_i;
    assign fab_in_o[g]  = pad_in_i[g] & ~drive_i;
  end
endmodule

// File: rtl/fabric_io_cell.sv
module fabric_io_cell
  import io_cell_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              cfg_clk_i,
  input  logic              rst_ni,
  input  logic              cfg_en_i,
  input  logic              cfg_sdi_i,
  output logic              cfg_sdo_o,
  input  logic              iso_ni,
  input  logic [DATA_W-1:0] fab_out_i,
  output logic [DATA_W-1:0] fab_in_o,
  output logic [DATA_W-1:0] pad_out_o,
  output logic              pad_oe_o,
  input  logic [DATA_W-1:0] pad_in_i
);
  dir_e dir;
  logic drive;

  io_cfg_bit u_cfg (
    .cfg_clk_i (cfg_clk_i),
    .rst_ni    (rst_ni),
    .cfg_en_i  (cfg_en_i),
    .cfg_sdi_i (cfg_sdi_i),
    .dir_o     (dir),
    .cfg_sdo_o (cfg_sdo_o)
  );

  io_dir_ctrl u_dir (
    .dir_i   (dir),
    .iso_ni  (iso_ni),
    .drive_o (drive)
  );

  io_path_gate #(.DATA_W(DATA_W)) u_gate (
    .drive_i   (drive),
    .fab_out_i (fab_out_i),
    .pad_in_i  (pad_in_i),
    .pad_out_o (pad_out_o),
    .fab_in_o  (fab_in_o)
  );

  assign pad_oe_o = drive;

  assert_iso_receive_R6: assert property (@(posedge cfg_clk_i) disable iff (!rst_ni)
    !iso_ni |-> !pad_oe_o && pad_out_o == '0);
  assert_quiet_pad_R4: assert property (@(posedge cfg_clk_i) disable iff (!rst_ni)
    !pad_oe_o |-> pad_out_o == '0 && fab_in_o == pad_in_i);
  assert_quiet_fab_R5: assert property (@(posedge cfg_clk_i) disable iff (!rst_ni)
    pad_oe_o |-> fab_in_o == '0 && pad_out_o == fab_out_i);
  assert_oe_follows_bit_R7: assert property (@(posedge cfg_clk_i) disable iff (!rst_ni)
    iso_ni |-> pad_oe_o == !cfg_sdo_o);
endmodule

// File: tb/tb_fabric_io_cell.sv
module tb_fabric_io_cell;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, sdi = 1'b0, iso_n = 1'b1;
  logic [DATA_W-1:0] fo = '0, pi = '0;
  logic sdo, oe;
  logic [DATA_W-1:0] fi, po;

  int checks = 0, errors = 0, cyc = 0;
  int model_bit = 1;
  bit finished = 0;

  always #2 clk = ~clk;

  fabric_io_cell #(.DATA_W(DATA_W)) dut (
    .cfg_clk_i(clk), .rst_ni(rst_n), .cfg_en_i(en), .cfg_sdi_i(sdi),
    .cfg_sdo_o(sdo), .iso_ni(iso_n), .fab_out_i(fo), .fab_in_o(fi),
    .pad_out_o(po), .pad_oe_o(oe), .pad_in_i(pi)
  );

  // behavioural reference for the stored bit
  always @(posedge clk or negedge rst_n)
    if (!rst_n) model_bit <= 1;
    else if (en) model_bit <= int'(sdi);

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // per-clock comparison against the reference
  always @(negedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
    begin
      bit drv;
      string rq;
      drv = iso_n && model_bit == 0;
      rq  = !iso_n ? "R6" : (model_bit == 1 ? "R4" : "R5");
      chk("R2 sdo", int'(sdo), model_bit);
      chk({rq, " oe"}, int'(oe), int'(drv));
      chk({rq, " pad_out"}, int'(po), drv ? int'(fo) : 0);
      chk({rq, " fab_in"}, int'(fi), drv ? 0 : int'(pi));
    end
  end

  task automatic step(logic e, logic d, logic i, logic [DATA_W-1:0] f, logic [DATA_W-1:0] p);
    @(posedge clk); #1;
    en = e; sdi = d; iso_n = i; fo = f; pi = p;
  endtask

  initial begin
    fo = 8'hA5; pi = 8'h5A;
    repeat (2) @(negedge clk);
    chk("R1 oe in reset", int'(oe), 0);
    chk("R1 sdo in reset", int'(sdo), 1);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sdo after reset", int'(sdo), 1);
    chk("R4 fab_in after reset", int'(fi), 'h5A);

    // shift a 0 in: drive mode
    step(1, 0, 1, 8'hA5, 8'h5A);
    step(0, 1, 1, 8'hA5, 8'h5A);
    @(negedge clk);
    chk("R5 oe", int'(oe), 1);
    chk("R8 pad_out lanes", int'(po), 'hA5);
    chk("R5 fab_in quiet", int'(fi), 0);

    // enable low, sdi toggling: hold
    for (int k = 0; k < 4; k++) step(0, k[0], 1, 8'hFF, 8'hFF);
    @(negedge clk);
    chk("R3 held bit", int'(sdo), 0);
    chk("R5 fab_in quiet all ones", int'(fi), 0);

    // isolation override in drive mode
    step(0, 1, 0, 8'hFF, 8'h3C);
    @(negedge clk);
    chk("R6 oe forced off", int'(oe), 0);
    chk("R6 pad_out quiet", int'(po), 0);
    chk("R6 fab_in passes", int'(fi), 'h3C);
    step(0, 1, 1, 8'h5A, 8'h3C);
    @(negedge clk);
    chk("R7 bit kept", int'(sdo), 0);
    chk("R7 mode restored", int'(oe), 1);

    // back to receive mode
    step(1, 1, 1, 8'hFF, 8'hA5);
    step(0, 0, 1, 8'hFF, 8'hA5);
    @(negedge clk);
    chk("R2 shifted 1", int'(sdo), 1);
    chk("R8 fab_in lanes", int'(fi), 'hA5);
    chk("R4 pad_out quiet", int'(po), 0);

    // isolation in receive mode, alternating shifts
    step(0, 0, 0, 8'h0F, 8'hF0);
    for (int k = 0; k < 6; k++) step(1, k[0], k[1], 8'h11 * k[3:0], 8'h0F);
    step(0, 0, 1, 8'h00, 8'h00);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule